// File: doc/BRIEF.md
# Segmented Two-Way Address Translation Buffer

This block maps 32-bit effective addresses from one access stream, instruction fetch or data, to 32-bit physical addresses. The four most significant effective-address bits select one of sixteen segment registers. Each segment register holds a 24-bit segment identifier. That identifier is joined with the remaining 28 address bits to form a 52-bit virtual address. The virtual page number is then looked up in a two-way set-associative buffer of page translations, which holds 64 entries for 4-Kbyte pages.

Hardware does not walk any page table. A lookup that finds no entry reports a miss, and software then loads the translation through a refill port. Software can also drop single entries by address, but only in supervisor mode, or clear the whole buffer in one cycle. Each entry carries one key bit that marks it as reachable from supervisor mode only.

Top module: `seg_tlb`

## Requirements
- R1: After reset the response outputs (`rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_prot`) are low, and every entry is invalid, so the first lookups miss.
- R2: `req_ea[31:28]` selects the segment register. The tag compares the 24-bit segment identifier together with `req_ea[27:17]`. The same effective address misses after its segment register is given another identifier, and hits again once the register is restored.
- R3: On a hit, `rsp_pa` equals the stored 20-bit page frame number in bits 31:12, followed by `req_ea[11:0]` unchanged.
- R4: The response appears on the clock edge after `req_valid`. While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_prot` is high. While `rsp_valid` is low, all three are low.
- R5: The set index is `req_ea[16:12]`, which gives 32 sets of two ways. Two pages with the same index stay resident together.
- R6: Each set has one least-recently-used bit. A refill of a new page replaces the way that this bit names. A successful hit, or a refill into a way, makes the other way the next victim.
- R7: A refill whose page is already present overwrites that way in place. It evicts no other page.
- R8: A supervisor invalidate (`inv_en` with `inv_super`=1) clears only the entry that matches the page of `inv_ea`. The other way of the set is left intact.
- R9: An invalidate issued with `inv_super`=0 is ignored.
- R10: `inv_all` clears every valid bit in one cycle. It takes priority over a refill or invalidate in the same cycle.
- R11: An entry refilled with `wr_sup_only`=1 reports `rsp_prot` rather than a hit to a lookup with `req_super`=0. A lookup with `req_super`=1 gets a normal hit.
- R12: A lookup issued in the same cycle as a refill sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sr_we | input | 1 | Segment register write enable |
| sr_idx | input | 4 | Segment register number |
| sr_vsid | input | 24 | Segment identifier to store |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address to translate |
| req_super | input | 1 | Lookup made in supervisor mode |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and allowed |
| rsp_miss | output | 1 | No translation found |
| rsp_prot | output | 1 | Found, but the entry is supervisor-only |
| rsp_pa | output | 32 | Physical address, meaningful on hit |
| wr_en | input | 1 | Refill write |
| wr_ea | input | 32 | Effective address of the page being loaded |
| wr_ppn | input | 20 | Physical page frame number |
| wr_sup_only | input | 1 | Entry reachable from supervisor mode only |
| inv_en | input | 1 | Invalidate by address |
| inv_ea | input | 32 | Address whose entry is dropped |
| inv_super | input | 1 | Invalidate issued in supervisor mode |
| inv_all | input | 1 | Clear every entry |

## Verification
The bench builds the block with its default parameters: 16 segments, 24-bit identifiers, 4-Kbyte pages and 32 sets. Three pages share index 5, so one set is filled past its two ways, and that brings eviction, least-recently-used refresh and in-place overwrite within reach. Changing the identifier in a segment register while the buffer is unchanged shows that the segment identifier is part of the tag.

// File: rtl/seg_tlb.sv
module seg_tlb #(
  parameter int EA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEG_SEL_W = 4,
  parameter int VSID_W    = 24,
  parameter int SET_BITS  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sr_we,
  input  logic [SEG_SEL_W-1:0]     sr_idx,
  input  logic [VSID_W-1:0]        sr_vsid,
  input  logic                     req_valid,
  input  logic [EA_W-1:0]          req_ea,
  input  logic                     req_super,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_miss,
  output logic                     rsp_prot,
  output logic [PA_W-1:0]          rsp_pa,
  input  logic                     wr_en,
  input  logic [EA_W-1:0]          wr_ea,
  input  logic [PA_W-PAGE_BITS-1:0] wr_ppn,
  input  logic                     wr_sup_only,
  input  logic                     inv_en,
  input  logic [EA_W-1:0]          inv_ea,
  input  logic                     inv_super,
  input  logic                     inv_all
);
  localparam int NSEG  = 1 << SEG_SEL_W;
  localparam int NSETS = 1 << SET_BITS;
  localparam int OFF_W = EA_W - SEG_SEL_W;
  localparam int VPN_W = VSID_W + OFF_W - PAGE_BITS;
  localparam int TAG_W = VPN_W - SET_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;

  logic [VSID_W-1:0] seg_q [NSEG];
  logic [NSETS-1:0]  vld_q [2];
  logic [TAG_W-1:0]  tag_q [2][NSETS];
  logic [PPN_W-1:0]  ppn_q [2][NSETS];
  logic              sup_q [2][NSETS];
  logic [NSETS-1:0]  lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) seg_q[i] <= '0;
    end else if (sr_we) begin
      seg_q[sr_idx] <= sr_vsid;
    end
  end

  logic [VPN_W-1:0] lk_vpn, wr_vpn, iv_vpn;
  assign lk_vpn = {seg_q[req_ea[EA_W-1 -: SEG_SEL_W]], req_ea[OFF_W-1:PAGE_BITS]};
  assign wr_vpn = {seg_q[wr_ea[EA_W-1 -: SEG_SEL_W]],  wr_ea[OFF_W-1:PAGE_BITS]};
  assign iv_vpn = {seg_q[inv_ea[EA_W-1 -: SEG_SEL_W]], inv_ea[OFF_W-1:PAGE_BITS]};

  logic [SET_BITS-1:0] lk_idx, wr_idx, iv_idx;
  logic [TAG_W-1:0]    lk_tag, wr_tag, iv_tag;
  assign lk_idx = lk_vpn[SET_BITS-1:0];
  assign wr_idx = wr_vpn[SET_BITS-1:0];
  assign iv_idx = iv_vpn[SET_BITS-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:SET_BITS];
  assign wr_tag = wr_vpn[VPN_W-1:SET_BITS];
  assign iv_tag = iv_vpn[VPN_W-1:SET_BITS];

  logic [1:0] lk_match, wr_match, iv_match;
  for (genvar w = 0; w < 2; w++) begin : g_way
    assign lk_match[w] = vld_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
    assign wr_match[w] = vld_q[w][wr_idx] && (tag_q[w][wr_idx] == wr_tag);
    assign iv_match[w] = vld_q[w][iv_idx] && (tag_q[w][iv_idx] == iv_tag);
  end

  logic lk_way, lk_any, lk_ok, wr_way, wr_go, iv_go;
  assign lk_way = lk_match[1];
  assign lk_any = |lk_match;
  assign lk_ok  = req_super || !sup_q[lk_way][lk_idx];
  assign wr_way = (|wr_match) ? wr_match[1] : lru_q[wr_idx];
  assign iv_go  = inv_en && inv_super && !inv_all;
  assign wr_go  = wr_en && !inv_all && !iv_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && lk_any && lk_ok;
      rsp_miss  <= req_valid && !lk_any;
      rsp_prot  <= req_valid && lk_any && !lk_ok;
      rsp_pa    <= {ppn_q[lk_way][lk_idx], req_ea[PAGE_BITS-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      lru_q    <= '0;
    end else begin
      if (req_valid && lk_any && lk_ok) lru_q[lk_idx] <= ~lk_way;
      if (inv_all) begin
        vld_q[0] <= '0;
        vld_q[1] <= '0;
      end else if (iv_go) begin
        if (iv_match[0]) vld_q[0][iv_idx] <= 1'b0;
        if (iv_match[1]) vld_q[1][iv_idx] <= 1'b0;
      end else if (wr_go) begin
        vld_q[wr_way][wr_idx] <= 1'b1;
        lru_q[wr_idx]         <= ~wr_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      tag_q[wr_way][wr_idx] <= wr_tag;
      ppn_q[wr_way][wr_idx] <= wr_ppn;
      sup_q[wr_way][wr_idx] <= wr_sup_only;
    end
  end

  // R4
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_prot}));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot));
  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_pa[PAGE_BITS-1:0] == $past(req_ea[PAGE_BITS-1:0])));
  // R10
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all ##1 req_valid |=> rsp_miss);
  // R4
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/seg_tlb_tb.sv
module seg_tlb_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_we = 1'b0;
  logic [3:0]  sr_idx = '0;
  logic [23:0] sr_vsid = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic        req_super = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot;
  logic [31:0] rsp_pa;
  logic        wr_en = 1'b0;
  logic [31:0] wr_ea = '0;
  logic [19:0] wr_ppn = '0;
  logic        wr_sup_only = 1'b0;
  logic        inv_en = 1'b0;
  logic [31:0] inv_ea = '0;
  logic        inv_super = 1'b0;
  logic        inv_all = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_tlb u_dut (
    .clk(clk), .rst_n(rst_n),
    .sr_we(sr_we), .sr_idx(sr_idx), .sr_vsid(sr_vsid),
    .req_valid(req_valid), .req_ea(req_ea), .req_super(req_super),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_prot(rsp_prot), .rsp_pa(rsp_pa),
    .wr_en(wr_en), .wr_ea(wr_ea), .wr_ppn(wr_ppn), .wr_sup_only(wr_sup_only),
    .inv_en(inv_en), .inv_ea(inv_ea), .inv_super(inv_super), .inv_all(inv_all)
  );

  localparam logic [31:0] EA_A = 32'h1234_5678;
  localparam logic [31:0] EA_B = 32'h1236_5000;
  localparam logic [31:0] EA_C = 32'h1238_5000;
  localparam logic [31:0] EA_D = 32'h1230_A111;
  localparam logic [31:0] EA_E = 32'h7000_3004;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // result encoding: 1 hit, 2 miss, 4 prot
  task automatic lookup(input logic [31:0] ea, input logic sup,
                        output logic [2:0] res, output logic [31:0] pa);
    req_valid = 1'b1; req_ea = ea; req_super = sup;
    @(negedge clk);
    req_valid = 1'b0;
    res = {rsp_prot, rsp_miss, rsp_hit};
    pa  = rsp_pa;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] ea, input logic [19:0] ppn);
    logic [2:0] r; logic [31:0] pa;
    lookup(ea, 1'b1, r, pa);
    check(req, {61'd0, r}, 64'd1);
    check(req, {32'd0, pa}, {32'd0, ppn, ea[11:0]});
  endtask

  task automatic expect_miss(input string req, input logic [31:0] ea);
    logic [2:0] r; logic [31:0] pa;
    lookup(ea, 1'b1, r, pa);
    check(req, {61'd0, r}, 64'd2);
  endtask

  task automatic set_seg(input logic [3:0] idx, input logic [23:0] v);
    sr_we = 1'b1; sr_idx = idx; sr_vsid = v;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic refill(input logic [31:0] ea, input logic [19:0] ppn, input logic so);
    wr_en = 1'b1; wr_ea = ea; wr_ppn = ppn; wr_sup_only = so;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic invalidate(input logic [31:0] ea, input logic sup);
    inv_en = 1'b1; inv_ea = ea; inv_super = sup;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R1 flags", {61'd0, rsp_prot, rsp_miss, rsp_hit}, 64'd0);
    expect_miss("R1 empty", EA_A);
    expect_miss("R1 empty", 32'h0);
  endtask

  task automatic test_basic();
    set_seg(4'h1, 24'hABCDEF);
    refill(EA_A, 20'h11111, 1'b0);
    expect_hit("R3 translate", EA_A, 20'h11111);
    expect_hit("R3 offset", EA_A | 32'hFFF, 20'h11111);
    expect_miss("R4 other page", EA_A + 32'h1000);
  endtask

  task automatic test_segment();
    set_seg(4'h1, 24'h000123);
    expect_miss("R2 new vsid", EA_A);
    set_seg(4'h1, 24'hABCDEF);
    expect_hit("R2 restored", EA_A, 20'h11111);
  endtask

  task automatic test_lru();
    refill(EA_B, 20'h22222, 1'b0);
    expect_hit("R5 way a", EA_A, 20'h11111);
    expect_hit("R5 way b", EA_B, 20'h22222);
    expect_hit("R6 touch A", EA_A, 20'h11111);
    refill(EA_C, 20'h33333, 1'b0);
    expect_miss("R6 B evicted", EA_B);
    expect_hit("R6 A kept", EA_A, 20'h11111);
    expect_hit("R6 C loaded", EA_C, 20'h33333);
  endtask

  task automatic test_overwrite();
    refill(EA_A, 20'h44444, 1'b0);
    expect_hit("R7 new ppn", EA_A, 20'h44444);
    expect_hit("R7 C kept", EA_C, 20'h33333);
  endtask

  task automatic test_same_cycle();
    logic [2:0] r; logic [31:0] pa;
    wr_en = 1'b1; wr_ea = EA_D; wr_ppn = 20'h55555; wr_sup_only = 1'b0;
    req_valid = 1'b1; req_ea = EA_D; req_super = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    r = {rsp_prot, rsp_miss, rsp_hit};
    check("R12 old state", {61'd0, r}, 64'd2);
    expect_hit("R12 after", EA_D, 20'h55555);
  endtask

  task automatic test_invalidate();
    invalidate(EA_C, 1'b0);
    expect_hit("R9 user inv ignored", EA_C, 20'h33333);
    invalidate(EA_A, 1'b1);
    expect_miss("R8 A dropped", EA_A);
    expect_hit("R8 C intact", EA_C, 20'h33333);
  endtask

  task automatic test_key();
    logic [2:0] r; logic [31:0] pa;
    set_seg(4'h7, 24'h00BEEF);
    refill(EA_E, 20'h66666, 1'b1);
    lookup(EA_E, 1'b0, r, pa);
    check("R11 user prot", {61'd0, r}, 64'd4);
    expect_hit("R11 super hit", EA_E, 20'h66666);
  endtask

  task automatic test_flush();
    inv_all = 1'b1;
    wr_en = 1'b1; wr_ea = EA_A; wr_ppn = 20'h77777; wr_sup_only = 1'b0;
    @(negedge clk);
    inv_all = 1'b0; wr_en = 1'b0;
    expect_miss("R10 C gone", EA_C);
    expect_miss("R10 D gone", EA_D);
    expect_miss("R10 E gone", EA_E);
    expect_miss("R10 refill blocked", EA_A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_segment();
    test_lru();
    test_overwrite();
    test_same_cycle();
    test_invalidate();
    test_key();
    test_flush();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule